// File: doc/BRIEF.md
# Reloadable Countdown Interval Timer

A memory-mapped countdown timer sitting behind a single-register Wishbone-style slave port. Software writes a 32-bit word. The top bit picks the mode: one-shot or periodic. The remaining 31 bits supply the start value, and that value is also stored for reloads. While the run-enable input is high (the controlled processor is not halted), the count drops by one per clock. When the count steps off one, the block raises a single-cycle timeout pulse. A one-shot timer then rests at zero. A periodic timer instead restarts from the stored value, so its pulses repeat every N enabled cycles.

The timeout pulse has the same shape whatever it drives. It can feed an interrupt input for an interval timer, or a reset request for a watchdog. Writing zero disarms the timer quietly.

The control is a three-state machine:

- `TMR_IDLE`: the count is zero and nothing happens.
- `TMR_ONESHOT`: counting down once.
- `TMR_PERIODIC`: counting down with reload.

The transitions are:

- Any write with a non-zero value goes to `TMR_ONESHOT` or `TMR_PERIODIC` according to bit 31.
- Any write of a zero value goes to `TMR_IDLE`.
- `TMR_ONESHOT` at count one with run-enable goes to `TMR_IDLE` (expiry).
- `TMR_PERIODIC` at count one with run-enable stays in `TMR_PERIODIC` and reloads.

Top module: `countdown_timer`

## Requirements
- R1: After synchronous reset the read data is 0, the timeout output is 0 and the acknowledge is 0.
- R2: A write (cyc, stb and we high at a clock edge) loads bits 30:0 as both the count and the reload value, and stores bit 31 as the mode (1 = periodic). The read data always shows the mode in bit 31 and the current count in bits 30:0.
- R3: In either running state the count decreases by exactly one on every clock edge at which run-enable is high and no write occurs.
- R4: While run-enable is low the count holds and no timeout occurs.
- R5: In one-shot mode, the edge at which the count steps from 1 to 0 is followed by a timeout output high for exactly one clock. The count then stays at 0 with no further pulses.
- R6: In periodic mode, at the edge where the count would step from 1, it reloads the stored value and emits a one-clock timeout. With reload value N the timeout repeats every N enabled cycles; N = 1 gives a timeout on every enabled cycle.
- R7: Writing a value of zero in bits 30:0 puts the timer in TMR_IDLE with count 0 and produces no timeout, whatever the mode bit.
- R8: The acknowledge is high in the cycle after each edge that saw cyc and stb high, and low otherwise. The stall output is always 0.
- R9: A write on the same edge at which the count would expire takes priority: the count becomes the written value and no timeout is produced.
- R10: A read access (we low) does not change the count, the mode or the timeout output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Count enable; low while the processor is halted |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write word: bit 31 mode, bits 30:0 value |
| bus_ack | output | 1 | Acknowledge, one clock after the strobe |
| bus_stall | output | 1 | Always 0 |
| bus_rdata | output | 32 | Mode bit and current count |
| timeout | output | 1 | One-clock expiry pulse |

## Verification
A wrong state encoding or a stale count shows up in the read data in the very next cycle, because the count register drives the read word directly. A fault in the expiry or reload path shows up within one reload period. It appears as a missing pulse, an extra pulse or a wrong residual count, which the bench compares against pulse tallies and final counts derived from the written value and the number of enabled cycles. Collisions between a write and expiry, and pauses of run-enable, are placed so that the count and the timeout line reveal a wrong priority on the following edge.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [1:0] {
        TMR_IDLE     = 2'd0,
        TMR_ONESHOT  = 2'd1,
        TMR_PERIODIC = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/tmr_bus_port.sv
module tmr_bus_port (
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic stb,
    input  logic we,
    output logic wr_req,
    output logic ack,
    output logic stall
);
    logic sel;

    assign sel    = cyc && stb;
    assign wr_req = sel && we;
    assign stall  = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= sel;
    end

    AST_ACK_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        (cyc && stb) |=> ack); // R8
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
        !(cyc && stb) |=> !ack); // R8
    AST_NEVER_STALL: assert property (@(posedge clk) disable iff (rst)
        !stall); // R8
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import timer_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tmo
);
    tmr_state_t       state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [CNT_W-1:0] reload;
    logic             mode;
    logic             nxt_tmo;
    logic [CNT_W-1:0] wval;
    logic             wmode;
    logic             at_one;

    assign wval   = wdata[CNT_W-1:0];
    assign wmode  = wdata[DATA_W-1];
    assign at_one = (cnt == CNT_W'(1));

    // Next state and next count
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_tmo   = 1'b0;
        if (wr) begin
            nxt_cnt = wval;
            if (wval == '0)  nxt_state = TMR_IDLE;
            else if (wmode)  nxt_state = TMR_PERIODIC;
            else             nxt_state = TMR_ONESHOT;
        end else if (run_en) begin
            unique case (state)
                TMR_IDLE: begin
                    nxt_cnt = '0;
                end
                TMR_ONESHOT: begin
                    if (at_one) begin
                        nxt_cnt   = '0;
                        nxt_state = TMR_IDLE;
                        nxt_tmo   = 1'b1;
                    end else begin
                        nxt_cnt = cnt - CNT_W'(1);
                    end
                end
                TMR_PERIODIC: begin
                    if (at_one) begin
                        nxt_cnt = reload;
                        nxt_tmo = 1'b1;
                    end else begin
                        nxt_cnt = cnt - CNT_W'(1);
                    end
                end
                default: begin
                    nxt_cnt   = '0;
                    nxt_state = TMR_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TMR_IDLE;
            cnt    <= '0;
            reload <= '0;
            mode   <= 1'b0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            if (wr) begin
                reload <= wval;
                mode   <= wmode;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) tmo <= 1'b0;
        else     tmo <= nxt_tmo;
    end

    assign rdata = {mode, cnt};

    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == TMR_IDLE) |-> (cnt == '0)); // R5
    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !wr) |=> ($stable(cnt) && !tmo)); // R4
    AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        tmo |-> ($past(cnt) == CNT_W'(1) && $past(run_en) && !$past(wr))); // R5
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        (tmo && mode) |-> (cnt == reload)); // R6
    AST_ONESHOT_REST: assert property (@(posedge clk) disable iff (rst)
        (tmo && !mode) |-> (cnt == '0 && state == TMR_IDLE)); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cnt == $past(wval) && !tmo)); // R9
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              timeout
);
    logic wr_req;

    tmr_bus_port u_port (
        .clk    (clk),
        .rst    (rst),
        .cyc    (bus_cyc),
        .stb    (bus_stb),
        .we     (bus_we),
        .wr_req (wr_req),
        .ack    (bus_ack),
        .stall  (bus_stall)
    );

    tmr_count_core #(.DATA_W(DATA_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .wr     (wr_req),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .tmo    (timeout)
    );
endmodule

// File: tb/test_countdown_timer.sv
module test_countdown_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        bus_cyc = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic        bus_stall;
    logic [31:0] bus_rdata;
    logic        timeout;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses;

    always #2 clk = ~clk;

    countdown_timer i_countdown_timer (
        .clk(clk), .rst(rst), .run_en(run_en),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_stall(bus_stall),
        .bus_rdata(bus_rdata), .timeout(timeout)
    );

    // write word, cycles with run_en, expected read word, expected pulses
    localparam int NV = 9;
    localparam logic [87:0] VEC [NV] = '{
        {32'h0000000A, 16'd4, 32'h00000006, 8'd0},
        {32'h00000005, 16'd5, 32'h00000000, 8'd1},
        {32'h00000003, 16'd8, 32'h00000000, 8'd1},
        {32'h80000004, 16'd4, 32'h80000004, 8'd1},
        {32'h80000004, 16'd9, 32'h80000003, 8'd2},
        {32'h80000001, 16'd3, 32'h80000001, 8'd3},
        {32'h00000000, 16'd5, 32'h00000000, 8'd0},
        {32'h7FFFFFFF, 16'd2, 32'h7FFFFFFD, 8'd0},
        {32'h80000000, 16'd3, 32'h80000000, 8'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // at a negedge: one bus write, returns at the next negedge
    task automatic bus_write(input logic [31:0] w, input logic en);
        run_en = en;
        bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_wdata = w;
        @(posedge clk); @(negedge clk);
        bus_cyc = 0; bus_stb = 0; bus_we = 0;
        if (timeout) pulses++;
    endtask

    task automatic run(input int n, input logic en);
        run_en = en;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (timeout) pulses++;
        end
        run_en = 0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 timeout", {31'b0, timeout}, 32'h0);
        check("R1 ack", {31'b0, bus_ack}, 32'h0);
        check("R8 stall", {31'b0, bus_stall}, 32'h0);

        // table walk: R2 R3 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            pulses = 0;
            bus_write(VEC[v][87:56], 1'b0);
            check("R8 ack after write", {31'b0, bus_ack}, 32'h1);
            pulses = 0;
            run(int'(VEC[v][55:40]), 1'b1);
            check("R2/R3/R6 count", bus_rdata, VEC[v][39:8]);
            check("R5/R6/R7 pulses", pulses, {24'b0, VEC[v][7:0]});
        end

        // R4 pause
        pulses = 0;
        bus_write(32'h00000014, 1'b0);
        run(3, 1'b1);
        check("R3 after 3", bus_rdata, 32'h11);
        run(5, 1'b0);
        check("R4 held", bus_rdata, 32'h11);
        run(2, 1'b1);
        check("R4 resumed", bus_rdata, 32'h0F);
        check("R4 no pulse", pulses, 0);

        // R8/R10 bus read does not alter state
        bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_wdata = 32'h80000003;
        check("R8 no early ack", {31'b0, bus_ack}, 32'h0);
        @(posedge clk); @(negedge clk);
        bus_cyc = 0; bus_stb = 0;
        check("R8 read ack", {31'b0, bus_ack}, 32'h1);
        check("R10 read data", bus_rdata, 32'h0F);
        @(posedge clk); @(negedge clk);
        check("R8 ack drops", {31'b0, bus_ack}, 32'h0);
        check("R10 count kept", bus_rdata, 32'h0F);

        // R5 exact pulse width
        bus_write(32'h00000002, 1'b0);
        run_en = 1;
        @(posedge clk); @(negedge clk);
        check("R5 no pulse at 2->1", {31'b0, timeout}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R5 pulse at 1->0", {31'b0, timeout}, 32'h1);
        @(posedge clk); @(negedge clk);
        check("R5 pulse one clock", {31'b0, timeout}, 32'h0);
        check("R5 rests at zero", bus_rdata, 32'h0);
        run_en = 0;

        // R9 write collides with expiry
        pulses = 0;
        bus_write(32'h00000002, 1'b0);
        run(1, 1'b1);
        bus_write(32'h80000007, 1'b1);
        check("R9 no pulse", pulses, 0);
        check("R9 new value", bus_rdata, 32'h80000007);
        run(7, 1'b1);
        check("R9 period pulse", pulses, 1);
        check("R6 reloaded", bus_rdata, 32'h80000007);

        // R7 disarm while running
        pulses = 0;
        bus_write(32'h80000005, 1'b0);
        run(2, 1'b1);
        bus_write(32'h00000000, 1'b1);
        run(10, 1'b1);
        check("R7 silent", pulses, 0);
        check("R7 zero", bus_rdata, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule